// File: doc/BRIEF.md
# Branch Target and Direction Predictor

This block sits in the fetch stage. The fetch address goes in, and in the same cycle three answers come out. The first says whether the address is a known branch. The second gives the direction to take. The third gives the address to fetch next. Two tables hold the block's state:

- A direct-mapped target table. Each entry has a valid bit, an address tag and a stored target. The tag check stops the table from supplying a target that belongs to some other instruction.
- A counter table of 2-bit saturating counters. It is indexed by the fetch address and has no tags, so branches whose low address bits match share a counter.

The direction comes from the counter, but only when the target table confirms that the address is a branch.

When a branch resolves, the back end presents the branch address, its outcome and its target on the update port. The counter at that address is always trained. A taken outcome also writes the target entry, whether it allocates a new entry or overwrites an old one. A not-taken outcome leaves the target table alone. A lookup made in the same cycle as an update to the same entry returns the contents from before the update. The new contents can be seen from the next cycle on.

Top module: `bp_fetch_predictor`

## Requirements
- R1: After reset every target entry is invalid, so any lookup returns `pred_hit`=0, `pred_taken`=0 and `pred_next_pc` = `fetch_pc`+4.
- R2: A lookup hits only when the entry at index `fetch_pc[7:2]` is valid and its stored tag equals `fetch_pc[31:8]`. Another address with the same index but a different tag misses.
- R3: All counters reset to 1 (weakly not taken). A single taken update therefore raises a counter to 2, and 2 predicts taken.
- R4: Counter values 2 and 3 predict taken, and 0 and 1 predict not taken. A counter saturates at 3: after any number of taken updates, one not-taken update still leaves it predicting taken.
- R5: A counter saturates at 0: after any number of not-taken updates, one taken update leaves it at 1, which predicts not taken.
- R6: `pred_taken` is 1 only when `pred_hit` is 1 and the counter predicts taken. `pred_next_pc` is the stored target when `pred_taken` is 1, and `fetch_pc`+4 in every other case.
- R7: A not-taken update neither allocates a target entry nor changes a stored target.
- R8: A taken update writes the entry at its index, setting valid, tag and target and replacing any earlier contents. From the next cycle on, a lookup of that address hits.
- R9: The counter table is indexed by `fetch_pc[9:2]` and has no tag. Updates from another branch with the same low bits retrain the counter used by a branch that hits.
- R10: A lookup in the same cycle as an update to the same entry sees the contents from before the update.
- R11: Lookup results depend only on `fetch_pc` and the stored state, and are valid in the same cycle as `fetch_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_pc | input | 32 | Address being fetched |
| pred_hit | output | 1 | The target table holds this address |
| pred_taken | output | 1 | Predicted direction is taken |
| pred_next_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_target | input | 32 | Resolved target address |

## Verification
Lookup results are combinational. They are due in the cycle that presents `fetch_pc`, so the monitor samples them halfway through the low phase of the clock, after the driver has settled the inputs. An update takes effect at the next rising edge. Any check that depends on an update is therefore placed at least one cycle after the update is presented. The one exception is the same-cycle check of R10, which samples before that edge on purpose and expects the contents from before the update. Each expected lookup is queued by the driver in the cycle it applies the lookup, and the monitor takes it off the queue in that same cycle.

// File: rtl/bp_pkg.sv
package bp_pkg;
   typedef logic [1:0] ctr_t;

   localparam ctr_t CTR_RESET = 2'd1;
   localparam ctr_t CTR_MAX   = 2'd3;
   localparam ctr_t CTR_MIN   = 2'd0;

   function automatic ctr_t ctr_train(input ctr_t cur, input logic taken);
      ctr_t nxt;
      if (taken) nxt = (cur == CTR_MAX) ? cur : cur + 2'd1;
      else       nxt = (cur == CTR_MIN) ? cur : cur - 2'd1;
      return nxt;
   endfunction

   function automatic logic ctr_says_taken(input ctr_t c);
      return c[1];
   endfunction
endpackage

// File: rtl/bp_target_table.sv
module bp_target_table #(
   parameter int PC_W  = 32,
   parameter int DEPTH = 64,
   parameter int TAG_W = 24,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             rd_hit,
   output logic [PC_W-1:0]  rd_tgt,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PC_W-1:0]  wr_tgt
);
   logic [DEPTH-1:0]  vld_q;
   logic [TAG_W-1:0]  tag_q [DEPTH];
   logic [PC_W-1:0]   tgt_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   vld_q[e] <= 1'b0;
         else if (sel) vld_q[e] <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            tag_q[e] <= wr_tag;
            tgt_q[e] <= wr_tgt;
         end
      end
   end

   always_comb begin
      rd_hit = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
      rd_tgt = tgt_q[rd_idx];
   end
endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table
   import bp_pkg::*;
#(
   parameter int DEPTH = 256,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output ctr_t             rd_ctr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken
);
   ctr_t ctr_q [DEPTH];
   ctr_t wr_next;

   assign wr_next = ctr_train(ctr_q[wr_idx], wr_taken);

   for (genvar e = 0; e < DEPTH; e++) begin : g_ctr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ctr_q[e] <= CTR_RESET;
         else if (wr_en && (wr_idx == IDX_W'(e)))
            ctr_q[e] <= wr_next;
      end
   end

   assign rd_ctr = ctr_q[rd_idx];
endmodule

// File: rtl/bp_next_pc.sv
module bp_next_pc
   import bp_pkg::*;
#(
   parameter int PC_W  = 32,
   parameter int STEP  = 4
) (
   input  logic [PC_W-1:0] pc,
   input  logic            hit,
   input  ctr_t            ctr,
   input  logic [PC_W-1:0] tgt,
   output logic            taken,
   output logic [PC_W-1:0] next_pc
);
   always_comb begin
      taken   = hit && ctr_says_taken(ctr);
      next_pc = taken ? tgt : pc + PC_W'(STEP);
   end
endmodule

// File: rtl/bp_fetch_predictor.sv
module bp_fetch_predictor
   import bp_pkg::*;
#(
   parameter int PC_W      = 32,
   parameter int BTB_DEPTH = 64,
   parameter int BHT_DEPTH = 256,
   parameter int ALIGN_W   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   output logic            pred_hit,
   output logic            pred_taken,
   output logic [PC_W-1:0] pred_next_pc,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken,
   input  logic [PC_W-1:0] upd_target
);
   localparam int BTB_IW = $clog2(BTB_DEPTH);
   localparam int BHT_IW = $clog2(BHT_DEPTH);
   localparam int TAG_LO = ALIGN_W + BTB_IW;
   localparam int TAG_W  = PC_W - TAG_LO;
   localparam int STEP   = 1 << ALIGN_W;

   if ((1 << BTB_IW) != BTB_DEPTH) begin : g_bad_btb
      $error("BTB_DEPTH must be a power of two");
   end
   if ((1 << BHT_IW) != BHT_DEPTH) begin : g_bad_bht
      $error("BHT_DEPTH must be a power of two");
   end
   if (TAG_W < 1 || PC_W < ALIGN_W + BHT_IW) begin : g_bad_pc
      $error("PC_W too narrow for the chosen table depths");
   end

   logic unused_align;
   assign unused_align = ^upd_pc[ALIGN_W-1:0];

   logic              btb_hit;
   logic [PC_W-1:0]   btb_tgt;
   ctr_t              ctr_rd;

   bp_target_table #(
      .PC_W (PC_W), .DEPTH (BTB_DEPTH), .TAG_W (TAG_W)
   ) u_btb (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (fetch_pc[TAG_LO-1:ALIGN_W]),
      .rd_tag (fetch_pc[PC_W-1:TAG_LO]),
      .rd_hit (btb_hit),
      .rd_tgt (btb_tgt),
      .wr_en  (upd_valid && upd_taken),
      .wr_idx (upd_pc[TAG_LO-1:ALIGN_W]),
      .wr_tag (upd_pc[PC_W-1:TAG_LO]),
      .wr_tgt (upd_target)
   );

   bp_counter_table #(
      .DEPTH (BHT_DEPTH)
   ) u_bht (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (fetch_pc[ALIGN_W+BHT_IW-1:ALIGN_W]),
      .rd_ctr   (ctr_rd),
      .wr_en    (upd_valid),
      .wr_idx   (upd_pc[ALIGN_W+BHT_IW-1:ALIGN_W]),
      .wr_taken (upd_taken)
   );

   bp_next_pc #(
      .PC_W (PC_W), .STEP (STEP)
   ) u_sel (
      .pc      (fetch_pc),
      .hit     (btb_hit),
      .ctr     (ctr_rd),
      .tgt     (btb_tgt),
      .taken   (pred_taken),
      .next_pc (pred_next_pc)
   );

   assign pred_hit = btb_hit;
endmodule

// File: rtl/bp_predictor_chk.sv
module bp_predictor_chk #(
   parameter int PC_W    = 32,
   parameter int ALIGN_W = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] fetch_pc,
   input logic            pred_hit,
   input logic            pred_taken,
   input logic [PC_W-1:0] pred_next_pc,
   input logic            upd_valid,
   input logic [PC_W-1:0] upd_pc,
   input logic            upd_taken
);
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R1
   first_cycle_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !pred_hit);

   // R6
   taken_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pred_taken |-> pred_hit);

   // R6
   fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_taken |-> pred_next_pc == fetch_pc + PC_W'(1 << ALIGN_W));

   // R8
   alloc_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(upd_valid && upd_taken) && fetch_pc == $past(upd_pc))
         |-> pred_hit);

   // R11
   quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $stable(fetch_pc) && !$past(upd_valid))
         |-> ($stable(pred_hit) && $stable(pred_taken) && $stable(pred_next_pc)));
endmodule

bind bp_fetch_predictor bp_predictor_chk #(.PC_W(PC_W), .ALIGN_W(ALIGN_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .fetch_pc     (fetch_pc),
   .pred_hit     (pred_hit),
   .pred_taken   (pred_taken),
   .pred_next_pc (pred_next_pc),
   .upd_valid    (upd_valid),
   .upd_pc       (upd_pc),
   .upd_taken    (upd_taken)
);

// File: tb/sim_bp_fetch_predictor.sv
module sim_bp_fetch_predictor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        pred_hit, pred_taken;
   logic [31:0] pred_next_pc;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_taken = 1'b0;
   logic [31:0] upd_target = '0;

   always #10 clk = ~clk;

   bp_fetch_predictor u0 (
      .clk (clk), .rst_n (rst_n), .fetch_pc (fetch_pc),
      .pred_hit (pred_hit), .pred_taken (pred_taken), .pred_next_pc (pred_next_pc),
      .upd_valid (upd_valid), .upd_pc (upd_pc), .upd_taken (upd_taken),
      .upd_target (upd_target)
   );

   typedef struct {
      logic [31:0] pc;
      logic        hit;
      logic        tk;
      logic [31:0] nxt;
      string       rq;
   } exp_t;

   exp_t exp_q [$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 0;

   // Monitor: compares in the same cycle the driver queued the item
   always @(negedge clk) begin
      #5;
      while (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_chk++;
         if (pred_hit !== e.hit || pred_taken !== e.tk || pred_next_pc !== e.nxt) begin
            n_bad++;
            $display("FAIL %s pc=%h: got hit=%b tk=%b nxt=%h, expected hit=%b tk=%b nxt=%h",
                     e.rq, e.pc, pred_hit, pred_taken, pred_next_pc, e.hit, e.tk, e.nxt);
         end
      end
   end

   // Driver: one cycle of optional update and optional checked lookup
   task automatic cyc(input logic uv, input logic [31:0] upc, input logic utk,
                      input logic [31:0] utgt, input logic [31:0] lpc, input bit chk,
                      input logic ehit, input logic etk, input logic [31:0] enxt,
                      input string rq);
      exp_t e;
      @(negedge clk);
      #1;
      upd_valid = uv; upd_pc = upc; upd_taken = utk; upd_target = utgt;
      fetch_pc = lpc;
      if (chk) begin
         e.pc = lpc; e.hit = ehit; e.tk = etk; e.nxt = enxt; e.rq = rq;
         exp_q.push_back(e);
      end
      @(posedge clk);
   endtask

   task automatic train(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
      cyc(1'b1, pc, tk, tgt, 32'h0, 0, 0, 0, 0, "");
   endtask

   task automatic look(input logic [31:0] pc, input logic h, input logic t,
                       input logic [31:0] n, input string rq);
      cyc(1'b0, 32'h0, 1'b0, 32'h0, pc, 1, h, t, n, rq);
   endtask

   localparam logic [31:0] PA = 32'h0000_1000;
   localparam logic [31:0] PC_ = 32'h0000_1100;  // same target index, other tag
   localparam logic [31:0] PB = 32'h0000_1400;   // shares counter and target index
   localparam logic [31:0] PD = 32'h0000_5008;

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      look(PA, 0, 0, PA + 4, "R1");
      look(PD, 0, 0, PD + 4, "R1");
      // R10: update and lookup of the same entry in one cycle
      cyc(1'b1, PA, 1'b1, 32'h2000, PA, 1, 0, 0, PA + 4, "R10");
      look(PA, 1, 1, 32'h2000, "R3");
      look(PA, 1, 1, 32'h2000, "R8");
      look(PC_, 0, 0, PC_ + 4, "R2");
      // R11: consecutive different addresses resolve each in its own cycle
      look(PD, 0, 0, PD + 4, "R11");
      look(PA, 1, 1, 32'h2000, "R11");
      repeat (3) train(PA, 1'b1, 32'h2000);
      train(PA, 1'b0, 32'hDEAD_0000);
      look(PA, 1, 1, 32'h2000, "R4");
      look(PA, 1, 1, 32'h2000, "R7");
      repeat (3) train(PA, 1'b0, 32'hDEAD_0000);
      look(PA, 1, 0, PA + 4, "R6");
      train(PA, 1'b1, 32'h3000);
      look(PA, 1, 0, PA + 4, "R5");
      train(PA, 1'b1, 32'h3000);
      look(PA, 1, 1, 32'h3000, "R8");
      train(PD, 1'b0, 32'h7000);
      look(PD, 0, 0, PD + 4, "R7");
      train(PB, 1'b0, 32'h9000);
      train(PB, 1'b0, 32'h9000);
      look(PA, 1, 0, PA + 4, "R9");
      look(PB, 0, 0, PB + 4, "R2");
      // reset in mid-run clears every entry
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      look(PA, 0, 0, PA + 4, "R1");
      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got no completion, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule